// File: doc/BRIEF.md
# Processor Trace Message Filter

This block sits between a CPU core and a trace message sink. Each cycle it takes at most one branch event (the branch target address) and at most one data-access event (direction, address, data and a single-access strobe). It turns them into at most one trace message, which it holds in a single output register behind a valid/ready handshake. Branch events become either full synchronisation messages or compressed messages, and the block mixes the two at a programmable ratio. Data accesses pass through a three-bit filter mode. The mode picks the access direction, and it picks whether the address, the value or both are recorded.

A breakpoint unit sends one-cycle on and off pulses that open and close a global collection window. While the window is closed, a data access that carries its own single-access strobe is still traced, one message for that access. Nothing is buffered. An event that cannot be placed in the output register is lost. A lost event raises a sticky overflow flag and makes the next branch message a synchronisation message, so the decoder can recover.

Top module: `trace_msg_filter`

## Requirements
- R1: A branch event produces a message only when `cfg_branch_en` is 1 and collection is on. Otherwise it produces nothing.
- R2: Header codes are 00 for a compressed branch, 01 for a sync branch, 10 for a data address and 11 for a data value. A sync branch carries the full target in `msg_addr`. A compressed branch carries only the low `CMP_W` bits of the target, with the upper bits zero. Branch messages have `msg_dir`=0 and `msg_data`=0.
- R3: `cfg_sync_sel` values 1, 2 and 3 select an interval N of 4, 16 and 64. Counting from 0 after a restart, branch message k is a sync message exactly when k mod N = 0. Every other branch message is compressed.
- R4: `cfg_sync_sel`=0 makes every branch message a sync message. No compressed message appears.
- R5: The first branch message after reset, and the first after collection turns on, is a sync message. The interval count restarts there.
- R6: Collection is off after reset. `trig_on` turns it on and `trig_off` turns it off. When both are high in the same cycle, collection turns off. The new state governs events from the following cycle.
- R7: `cfg_dmode` selects what a data access produces.
  - 0: nothing.
  - 1: read address, header 10.
  - 2: write address, header 10.
  - 3: read or write address, header 10.
  - 4: read value with `msg_addr`=0, header 11.
  - 5: read value and address, header 11.
  - 6: write value and address, header 11.
  - 7: read or write value and address, header 11.
  - `msg_dir` is 1 for a write. Address messages carry `msg_data`=0.
- R8: While collection is on, every access that the mode selects is traced, whatever the value of `da_single`.
- R9: While collection is off, an access with `da_single`=1 that the mode selects gives exactly one message. Without the strobe it gives none.
- R10: A message appears on the cycle after its event. It stays unchanged while `msg_valid`=1 and `msg_ready`=0, and it is dropped once it is accepted.
- R11: An event that arrives while a message is stalled is discarded. It sets `ovf` (sticky until reset), and the next branch message is a sync message.
- R12: When a branch event and a traced data event fall in the same cycle, the branch message is emitted and the data event counts as lost, as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_branch_en | input | 1 | Branch trace enable |
| cfg_sync_sel | input | 2 | Sync interval select |
| cfg_dmode | input | 3 | Data-trace filter mode |
| trig_on | input | 1 | Collection-on pulse from breakpoint unit |
| trig_off | input | 1 | Collection-off pulse from breakpoint unit |
| br_valid | input | 1 | Branch event strobe |
| br_addr | input | ADDR_W | Branch target address |
| da_valid | input | 1 | Data-access event strobe |
| da_write | input | 1 | Access direction, 1 = write |
| da_single | input | 1 | Single-access trace strobe |
| da_addr | input | ADDR_W | Access address |
| da_data | input | DATA_W | Access value |
| msg_ready | input | 1 | Sink ready |
| msg_valid | output | 1 | Message present |
| msg_hdr | output | 2 | Message type header |
| msg_dir | output | 1 | Data direction, 1 = write |
| msg_addr | output | ADDR_W | Address payload |
| msg_data | output | DATA_W | Value payload |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with 16-bit address and data and a 6-bit compressed field. These widths keep the compressed payload easy to tell apart from the full target. The bench drives at least two whole periods of every sync interval, including the longest, 64-message interval, and computes each expected header from the message index. It sweeps all eight filter modes against both directions, both strobe values and both collection states, which covers the whole data-filter truth table. Stall sequences place the forced resynchronisation in the middle of an interval, where it differs from the regular pattern.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        HDR_BR_COMP = 2'b00,
        HDR_BR_SYNC = 2'b01,
        HDR_D_ADDR  = 2'b10,
        HDR_D_VAL   = 2'b11
    } hdr_e;

    typedef struct packed {
        logic take_rd;
        logic take_wr;
        logic with_addr;
        logic with_data;
    } dsel_t;

    localparam int unsigned MAX_INTERVAL = 64;

    function automatic int unsigned sync_interval(input logic [1:0] sel);
        return 32'd1 << (2 * sel);
    endfunction

    function automatic dsel_t decode_dmode(input logic [2:0] mode);
        dsel_t d;
        d = '0;
        case (mode)
            3'd1: begin d.take_rd = 1'b1; d.with_addr = 1'b1; end
            3'd2: begin d.take_wr = 1'b1; d.with_addr = 1'b1; end
            3'd3: begin d.take_rd = 1'b1; d.take_wr = 1'b1; d.with_addr = 1'b1; end
            3'd4: begin d.take_rd = 1'b1; d.with_data = 1'b1; end
            3'd5: begin d.take_rd = 1'b1; d.with_addr = 1'b1; d.with_data = 1'b1; end
            3'd6: begin d.take_wr = 1'b1; d.with_addr = 1'b1; d.with_data = 1'b1; end
            3'd7: begin
                d.take_rd = 1'b1; d.take_wr = 1'b1;
                d.with_addr = 1'b1; d.with_data = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/trc_collect.sv
module trc_collect (
    input  logic clk,
    input  logic rst,
    input  logic trig_on,
    input  logic trig_off,
    output logic coll_on,
    output logic turn_on
);
    logic coll_q;

    assign turn_on = !coll_q && trig_on && !trig_off;
    assign coll_on = coll_q;

    always_ff @(posedge clk) begin
        if (rst)
            coll_q <= 1'b0;
        else if (trig_off)
            coll_q <= 1'b0;
        else if (trig_on)
            coll_q <= 1'b1;
    end

    // R6: off pulse always wins
    a_r6_off_wins: assert property (@(posedge clk) disable iff (rst)
        trig_off |=> !coll_on);
    // R6: a lone on pulse opens the window
    a_r6_on_sets: assert property (@(posedge clk) disable iff (rst)
        (trig_on && !trig_off) |=> coll_on);

endmodule

// File: rtl/trc_sync_ctrl.sv
module trc_sync_ctrl
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sync_sel,
    input  logic       restart,
    input  logic       drop,
    input  logic       emit,
    output logic       is_sync
);
    localparam int CNT_W = $clog2(MAX_INTERVAL + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             force_q;
    logic [CNT_W:0]   limit;

    assign limit   = (CNT_W+1)'(sync_interval(sync_sel));
    assign is_sync = force_q || ({1'b0, cnt_q} >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            force_q <= 1'b1;
        end else begin
            if (emit)
                cnt_q <= is_sync ? CNT_W'(1) : cnt_q + CNT_W'(1);
            if (emit && is_sync)
                force_q <= 1'b0;
            if (restart || drop)
                force_q <= 1'b1;
        end
    end

    // R4: interval of one gives only sync messages
    a_r4_all_sync: assert property (@(posedge clk) disable iff (rst)
        (emit && sync_sel == 2'd0) |-> is_sync);
    // R5: a restart makes the next cycle's branch a sync one
    a_r5_restart_sync: assert property (@(posedge clk) disable iff (rst)
        restart |=> (emit |-> is_sync));
    // R11: a loss forces resynchronisation next cycle
    a_r11_drop_resync: assert property (@(posedge clk) disable iff (rst)
        drop |=> is_sync);
    // R3: counter never exceeds the longest interval
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_INTERVAL));

endmodule

// File: rtl/trc_data_filter.sv
module trc_data_filter
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [2:0]        mode,
    input  logic              coll_on,
    input  logic              da_valid,
    input  logic              da_write,
    input  logic              da_single,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic [DATA_W-1:0] da_data,
    output logic              want,
    output hdr_e              hdr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    dsel_t sel;
    logic  dir_ok;

    always_comb begin
        sel    = decode_dmode(mode);
        dir_ok = da_write ? sel.take_wr : sel.take_rd;
        want   = da_valid && dir_ok && (coll_on || da_single);
        hdr    = sel.with_data ? HDR_D_VAL : HDR_D_ADDR;
        addr   = sel.with_addr ? da_addr : '0;
        data   = sel.with_data ? da_data : '0;
    end

endmodule

// File: rtl/trc_out_stage.sv
module trc_out_stage
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_want,
    input  logic              br_sync,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic              da_want,
    input  hdr_e              da_hdr,
    input  logic              da_dir,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic [DATA_W-1:0] da_data,
    input  logic              msg_ready,
    output logic              msg_valid,
    output hdr_e              msg_hdr,
    output logic              msg_dir,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data,
    output logic              br_emit,
    output logic              drop,
    output logic              ovf
);
    localparam logic [ADDR_W-1:0] CMP_MASK = {{(ADDR_W-CMP_W){1'b0}}, {CMP_W{1'b1}}};

    logic slot_free;
    logic any_want;

    assign slot_free = !msg_valid || msg_ready;
    assign any_want  = br_want || da_want;
    assign br_emit   = br_want && slot_free;
    assign drop      = (any_want && !slot_free) || (br_want && da_want);

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_hdr   <= HDR_BR_COMP;
            msg_dir   <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            ovf       <= 1'b0;
        end else begin
            if (any_want && slot_free) begin
                msg_valid <= 1'b1;
                if (br_want) begin
                    msg_hdr  <= br_sync ? HDR_BR_SYNC : HDR_BR_COMP;
                    msg_dir  <= 1'b0;
                    msg_addr <= br_sync ? br_addr : (br_addr & CMP_MASK);
                    msg_data <= '0;
                end else begin
                    msg_hdr  <= da_hdr;
                    msg_dir  <= da_dir;
                    msg_addr <= da_addr;
                    msg_data <= da_data;
                end
            end else if (msg_ready) begin
                msg_valid <= 1'b0;
            end
            if (drop)
                ovf <= 1'b1;
        end
    end

    // R10: a stalled message holds still
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                       && $stable(msg_hdr) && $stable(msg_data)));
    // R11: overflow is sticky
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    // R12: a collision always yields the branch message
    a_r12_branch_first: assert property (@(posedge clk) disable iff (rst)
        (br_want && da_want && slot_free) |=> (msg_hdr == HDR_BR_COMP || msg_hdr == HDR_BR_SYNC));

endmodule

// File: rtl/trace_msg_filter.sv
module trace_msg_filter
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_branch_en,
    input  logic [1:0]        cfg_sync_sel,
    input  logic [2:0]        cfg_dmode,
    input  logic              trig_on,
    input  logic              trig_off,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic              da_valid,
    input  logic              da_write,
    input  logic              da_single,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic [DATA_W-1:0] da_data,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [1:0]        msg_hdr,
    output logic              msg_dir,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data,
    output logic              ovf
);
    logic              coll_on, turn_on;
    logic              br_want, br_sync, br_emit, drop;
    logic              da_want;
    hdr_e              da_hdr, out_hdr;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    assign br_want = br_valid && cfg_branch_en && coll_on;
    assign msg_hdr = out_hdr;

    trc_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .trig_on  (trig_on),
        .trig_off (trig_off),
        .coll_on  (coll_on),
        .turn_on  (turn_on)
    );

    trc_sync_ctrl u_sync (
        .clk      (clk),
        .rst      (rst),
        .sync_sel (cfg_sync_sel),
        .restart  (turn_on),
        .drop     (drop),
        .emit     (br_emit),
        .is_sync  (br_sync)
    );

    trc_data_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_filter (
        .mode      (cfg_dmode),
        .coll_on   (coll_on),
        .da_valid  (da_valid),
        .da_write  (da_write),
        .da_single (da_single),
        .da_addr   (da_addr),
        .da_data   (da_data),
        .want      (da_want),
        .hdr       (da_hdr),
        .addr      (f_addr),
        .data      (f_data)
    );

    trc_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .br_want   (br_want),
        .br_sync   (br_sync),
        .br_addr   (br_addr),
        .da_want   (da_want),
        .da_hdr    (da_hdr),
        .da_dir    (da_write),
        .da_addr   (f_addr),
        .da_data   (f_data),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_hdr   (out_hdr),
        .msg_dir   (msg_dir),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .br_emit   (br_emit),
        .drop      (drop),
        .ovf       (ovf)
    );

    // R1: branch messages need the enable bit
    a_r1_branch_gate: assert property (@(posedge clk) disable iff (rst)
        !cfg_branch_en |-> !br_emit);
    // R9: with collection off, only strobed accesses reach the output
    a_r9_off_strobe: assert property (@(posedge clk) disable iff (rst)
        (!coll_on && da_valid && !da_single && !br_want && !msg_valid) |=> !msg_valid);

endmodule

// File: tb/trace_msg_filter_bench.sv
`timescale 1ns/1ps
module trace_msg_filter_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_branch_en;
    logic [1:0]    cfg_sync_sel;
    logic [2:0]    cfg_dmode;
    logic          trig_on, trig_off;
    logic          br_valid;
    logic [AW-1:0] br_addr;
    logic          da_valid, da_write, da_single;
    logic [AW-1:0] da_addr;
    logic [DW-1:0] da_data;
    logic          msg_ready;
    logic          msg_valid;
    logic [1:0]    msg_hdr;
    logic          msg_dir;
    logic [AW-1:0] msg_addr;
    logic [DW-1:0] msg_data;
    logic          ovf;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    trace_msg_filter #(.ADDR_W(AW), .DATA_W(DW), .CMP_W(CW)) u_trace_msg_filter (
        .clk(clk), .rst(rst), .cfg_branch_en(cfg_branch_en), .cfg_sync_sel(cfg_sync_sel),
        .cfg_dmode(cfg_dmode), .trig_on(trig_on), .trig_off(trig_off),
        .br_valid(br_valid), .br_addr(br_addr), .da_valid(da_valid), .da_write(da_write),
        .da_single(da_single), .da_addr(da_addr), .da_data(da_data), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_hdr(msg_hdr), .msg_dir(msg_dir), .msg_addr(msg_addr),
        .msg_data(msg_data), .ovf(ovf)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_msg(input string tag, input logic v, input logic [1:0] h,
                             input logic d, input logic [AW-1:0] a, input logic [DW-1:0] x);
        n_cmp++;
        if (msg_valid !== v || (v && (msg_hdr !== h || msg_dir !== d ||
                                      msg_addr !== a || msg_data !== x))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b h=%0d d=%0b a=%h x=%h expected v=%0b h=%0d d=%0b a=%h x=%h",
                     tag, msg_valid, msg_hdr, msg_dir, msg_addr, msg_data, v, h, d, a, x);
        end
    endtask

    task automatic pulse(input logic on, input logic off);
        trig_on = on; trig_off = off;
        tick();
        trig_on = 1'b0; trig_off = 1'b0;
    endtask

    task automatic branch(input logic [AW-1:0] a);
        br_valid = 1'b1; br_addr = a;
        tick();
        br_valid = 1'b0;
    endtask

    task automatic access(input logic w, input logic s, input logic [AW-1:0] a, input logic [DW-1:0] x);
        da_valid = 1'b1; da_write = w; da_single = s; da_addr = a; da_data = x;
        tick();
        da_valid = 1'b0; da_single = 1'b0;
    endtask

    function automatic logic [AW-1:0] cmp(input logic [AW-1:0] a);
        return a & ((16'd1 << CW) - 16'd1);
    endfunction

    logic done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_branch_en = 1'b0; cfg_sync_sel = 2'd0; cfg_dmode = 3'd0;
        trig_on = 1'b0; trig_off = 1'b0; br_valid = 1'b0; br_addr = '0;
        da_valid = 1'b0; da_write = 1'b0; da_single = 1'b0; da_addr = '0; da_data = '0;
        msg_ready = 1'b1;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        check_msg("reset R10", 1'b0, 2'd0, 1'b0, '0, '0);
        check_bit("reset ovf R11", ovf, 1'b0);

        // R1: collection off, then enable bit clear
        cfg_branch_en = 1'b1;
        branch(16'h1234);
        check_msg("R1 coll off", 1'b0, 2'd0, 1'b0, '0, '0);
        pulse(1'b1, 1'b0);
        cfg_branch_en = 1'b0;
        branch(16'h2345);
        check_msg("R1 en clear", 1'b0, 2'd0, 1'b0, '0, '0);
        cfg_branch_en = 1'b1;

        // R3/R4/R5: sweep every interval over two periods and more
        for (int sel = 0; sel < 4; sel++) begin
            int n;
            cfg_sync_sel = 2'(sel);
            n = 1 << (2 * sel);
            pulse(1'b0, 1'b1);
            pulse(1'b1, 1'b0);
            for (int k = 0; k < 2 * n + 3; k++) begin
                logic [AW-1:0] a;
                a = AW'(k * 37 + sel * 1000 + 5);
                branch(a);
                if (k % n == 0)
                    check_msg(sel == 0 ? "R4 sync" : "R3 R5 sync", 1'b1, 2'd1, 1'b0, a, '0);
                else
                    check_msg("R3 R2 compressed", 1'b1, 2'd0, 1'b0, cmp(a), '0);
            end
        end

        // R6: simultaneous pulses turn collection off
        tick();
        pulse(1'b1, 1'b1);
        branch(16'h0777);
        check_msg("R6 both off", 1'b0, 2'd0, 1'b0, '0, '0);
        pulse(1'b1, 1'b1);
        branch(16'h0778);
        check_msg("R6 both stays off", 1'b0, 2'd0, 1'b0, '0, '0);
        cfg_sync_sel = 2'd2;
        pulse(1'b1, 1'b0);
        branch(16'h0779);
        check_msg("R6 R5 on sync", 1'b1, 2'd1, 1'b0, 16'h0779, '0);
        tick();

        // R7/R8/R9: full data filter sweep
        cfg_branch_en = 1'b0;
        for (int c = 0; c < 2; c++) begin
            pulse(1'b0, 1'b1);
            if (c == 1) pulse(1'b1, 1'b0);
            for (int m = 0; m < 8; m++) begin
                cfg_dmode = 3'(m);
                for (int w = 0; w < 2; w++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [AW-1:0] a;
                        logic [DW-1:0] x;
                        logic          selw, emit;
                        a = AW'(16'h4000 + m * 16 + w * 4 + s);
                        x = DW'(16'hA000 + m * 16 + w * 4 + s + c * 256);
                        selw = (w == 1) ? (m == 2 || m == 3 || m == 6 || m == 7)
                                        : (m == 1 || m == 3 || m == 4 || m == 5 || m == 7);
                        emit = selw && (c == 1 || s == 1);
                        access(1'(w), 1'(s), a, x);
                        check_msg(c == 1 ? "R7 R8 data" : "R7 R9 data", emit,
                                  (m >= 4) ? 2'd3 : 2'd2, 1'(w),
                                  (m == 4) ? '0 : a, (m >= 4) ? x : '0);
                    end
                end
            end
        end
        check_bit("R8 R9 no ovf", ovf, 1'b0);

        // R10/R11: stall, loss and forced resync mid-interval
        cfg_branch_en = 1'b1; cfg_dmode = 3'd0; cfg_sync_sel = 2'd2;
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        branch(16'h1100);
        check_msg("R5 first", 1'b1, 2'd1, 1'b0, 16'h1100, '0);
        branch(16'h1101);
        check_msg("R3 second", 1'b1, 2'd0, 1'b0, cmp(16'h1101), '0);
        tick();
        check_msg("R10 accepted", 1'b0, 2'd0, 1'b0, '0, '0);
        msg_ready = 1'b0;
        branch(16'h1102);
        check_msg("R10 loaded", 1'b1, 2'd0, 1'b0, cmp(16'h1102), '0);
        branch(16'h1103);
        check_msg("R10 R11 held", 1'b1, 2'd0, 1'b0, cmp(16'h1102), '0);
        check_bit("R11 ovf set", ovf, 1'b1);
        tick();
        check_msg("R10 still held", 1'b1, 2'd0, 1'b0, cmp(16'h1102), '0);
        msg_ready = 1'b1;
        tick();
        check_msg("R10 drained", 1'b0, 2'd0, 1'b0, '0, '0);
        branch(16'h1104);
        check_msg("R11 forced sync", 1'b1, 2'd1, 1'b0, 16'h1104, '0);
        branch(16'h1105);
        check_msg("R11 then compressed", 1'b1, 2'd0, 1'b0, cmp(16'h1105), '0);

        // R12: collision of branch and data
        cfg_dmode = 3'd7;
        br_valid = 1'b1; br_addr = 16'h1106;
        da_valid = 1'b1; da_write = 1'b1; da_addr = 16'h5555; da_data = 16'h6666;
        tick();
        br_valid = 1'b0; da_valid = 1'b0;
        check_msg("R12 branch wins", 1'b1, 2'd0, 1'b0, cmp(16'h1106), '0);
        check_bit("R12 ovf", ovf, 1'b1);
        cfg_dmode = 3'd0;
        branch(16'h1107);
        check_msg("R12 resync", 1'b1, 2'd1, 1'b0, 16'h1107, '0);
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule